// File: doc/BRIEF.md
# Cyclic Transparent TDM Serial Transmitter

This block sends bytes from a small transmit buffer as a raw serial bit stream with no framing of any kind: no flag octets, no checksum and no zero-bit stuffing. Bits are driven only while a programmable window (the timeslot) of a time-division frame is current. The frame is marked by a one-cycle frame sync pulse, and every clock cycle is one bit period.

Software loads between 1 and 64 bytes and then writes an 8-bit command byte. A plain start command sends the buffer once and raises an end-of-transmission flag. A start combined with the repeat bit loops the buffer forever, wrapping from the last byte back to the first. The loop ends only when a transmit-reset command arrives. Each transmission begins with one filler octet of all ones before the first stored byte. While nothing is being sent, the line carries ones.

Top module: `cyc_serial_tx`

## Requirements
- R1: After `rst` the outputs are `txd`=1 and `irq_flags`=0x00. While no transmission runs, every timeslot bit on `txd` is 1.
- R2: The buffer accepts writes (`wr_en` with `wr_data`) until it holds DEPTH=64 bytes. Any further write is ignored, so a full 64-byte buffer is sent with no 65th byte.
- R3: Stored bytes go out unchanged and most significant bit first, one bit per timeslot bit. The bit for frame position k is driven on `txd` in the clock cycle after the one in which position k is current.
- R4: A command byte with bit 3 (0x08, start) set and bit 5 clear sends the buffered bytes exactly once. After that the timeslot carries ones and the buffer is left empty.
- R5: Bit 6 (mask 0x40) of `irq_flags` rises in the same cycle that the last bit of a single-shot transmission appears on `txd`. The next accepted start command clears it, and a repeating transmission never sets it.
- R6: A command byte with bit 5 (0x20, repeat) and bit 3 both set, for example 0x2A, sends the buffer over and over, wrapping from the last byte back to the first.
- R7: A command byte with bit 0 (0x01, transmit reset) set stops any transmission and empties the buffer. From then on the timeslot carries ones. Bit 0 takes priority over bit 3 in the same command byte.
- R8: Every transmission starts with one octet of 0xFF before the first stored byte.
- R9: The timeslot starts at frame position `slot_pos` (position 0 is the cycle with `fsync` high) and lasts `slot_len` bits. Octets start only at slot offsets that are multiples of 8. With a 16-bit slot, the first octet may start at offset 8, and the following octets then continue in slot order.
- R10: Buffer writes are ignored while a transmission is armed or running.
- R11: A start command is ignored while the buffer is empty or while a transmission is armed or running.
- R12: Outside the timeslot `txd` is 1 and `txd_oe` equals `hold_high`. Inside the timeslot `txd_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync; high in the cycle of frame position 0 |
| slot_pos | input | POS_W (5) | First frame position of the timeslot |
| slot_len | input | POS_W+1 (6) | Timeslot length in bits |
| hold_high | input | 1 | Drive enable outside the timeslot (1 = drive ones, 0 = release) |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Byte to append to the buffer |
| cmd_valid | input | 1 | Command strobe |
| cmd_byte | input | 8 | Command: bit 0 reset, bit 3 start, bit 5 repeat, bit 1 message end (accepted, no effect) |
| txd | output | 1 | Serial data, registered |
| txd_oe | output | 1 | Output enable for `txd`, registered |
| irq_flags | output | 8 | Interrupt flags; bit 6 marks the end of a single-shot transmission |

## Verification
The assertions assume three things about the inputs: the slot fits inside the frame, `slot_pos` and `slot_len` stay constant while a transmission is armed or running, and each strobe is high for a single cycle. The bench drives `fsync` exactly every 32 cycles and changes the slot settings only while the transmitter is idle. It issues each command or write as a one-cycle pulse on a falling edge. It chooses the first stored byte with its top bit clear, so the first zero in the captured slot stream marks where the data begins. This lets the bench measure the filler octet and the alignment of the start without looking inside the design.

// File: rtl/cyctx_pkg.sv
package cyctx_pkg;
  localparam int CMD_RESET_BIT  = 0;
  localparam int CMD_END_BIT    = 1;
  localparam int CMD_START_BIT  = 3;
  localparam int CMD_REPEAT_BIT = 5;
  localparam int IRQ_DONE_BIT   = 6;
  localparam logic [7:0] FILL_OCTET = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/cyctx_slot_timer.sv
module cyctx_slot_timer #(
  parameter int FRAME_BITS = 32,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync,
  input  logic [POS_W-1:0] slot_pos,
  input  logic [POS_W:0]   slot_len,
  output logic             slot_act,
  output logic             slot_aligned
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0] cnt_q;
  logic [POS_W-1:0] cur;
  logic [POS_W:0]   offs;

  always_comb begin
    if (fsync)                cur = '0;
    else if (cnt_q == LAST_POS) cur = '0;
    else                      cur = cnt_q + 1'b1;
  end

  assign offs         = {1'b0, cur} - {1'b0, slot_pos};
  assign slot_act     = ({1'b0, cur} >= {1'b0, slot_pos}) && (offs < slot_len);
  assign slot_aligned = slot_act && (offs[2:0] == 3'd0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= LAST_POS;
    else     cnt_q <= cur;
  end

  // R9: without a sync pulse the frame position advances by one
  p_frame_step_r9: assert property (@(posedge clk) disable iff (rst)
    (!fsync && cnt_q != LAST_POS) |=> (cnt_q == POS_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/cyctx_buf_ram.sv
module cyctx_buf_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cyctx_engine.sv
module cyctx_engine
  import cyctx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  input  logic          slot_act,
  input  logic          slot_aligned,
  output logic          tx_bit,
  output logic          eng_idle,
  output logic          irq_done,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [7:0]    ram_wdata,
  output logic [AW-1:0] ram_raddr,
  input  logic [7:0]    ram_rdata
);
  tx_state_e      state;
  logic           cyc_q;
  logic [CW-1:0]  cnt_q;
  logic [AW-1:0]  rd_ptr;
  logic [AW-1:0]  byte_no;
  logic [2:0]     bit_idx;
  logic           junk_q;
  logic [7:0]     shreg;
  logic           irq_q;

  logic           cmd_rst, cmd_go, wr_ok, shift_en;
  logic [AW-1:0]  last_idx, next_ptr;

  assign cmd_rst  = cmd_valid && cmd_byte[CMD_RESET_BIT];
  assign cmd_go   = cmd_valid && cmd_byte[CMD_START_BIT] && !cmd_rst &&
                    (state == ST_IDLE) && (cnt_q != '0);
  assign wr_ok    = wr_en && (state == ST_IDLE) && (cnt_q < CW'(DEPTH)) && !cmd_rst;
  assign shift_en = slot_act && ((state == ST_RUN) || (state == ST_ARM && slot_aligned));
  assign last_idx = AW'(cnt_q - CW'(1));
  assign next_ptr = (rd_ptr == last_idx) ? '0 : rd_ptr + 1'b1;

  assign ram_we    = wr_ok;
  assign ram_waddr = cnt_q[AW-1:0];
  assign ram_wdata = wr_data;
  assign ram_raddr = rd_ptr;
  assign tx_bit    = shreg[7];
  assign eng_idle  = (state == ST_IDLE);
  assign irq_done  = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cyc_q   <= 1'b0;
      cnt_q   <= '0;
      rd_ptr  <= '0;
      byte_no <= '0;
      bit_idx <= '0;
      junk_q  <= 1'b1;
      shreg   <= FILL_OCTET;
      irq_q   <= 1'b0;
    end else begin
      if (wr_ok) cnt_q <= cnt_q + 1'b1;
      if (cmd_rst) begin
        state   <= ST_IDLE;
        cyc_q   <= 1'b0;
        cnt_q   <= '0;
        rd_ptr  <= '0;
        byte_no <= '0;
        bit_idx <= '0;
        junk_q  <= 1'b1;
        shreg   <= FILL_OCTET;
      end else if (cmd_go) begin
        state   <= ST_ARM;
        cyc_q   <= cmd_byte[CMD_REPEAT_BIT];
        irq_q   <= 1'b0;
        rd_ptr  <= '0;
        byte_no <= '0;
        bit_idx <= '0;
        junk_q  <= 1'b1;
        shreg   <= FILL_OCTET;
      end else if (shift_en) begin
        state   <= ST_RUN;
        bit_idx <= bit_idx + 1'b1;
        shreg   <= {shreg[6:0], 1'b1};
        if (bit_idx == 3'd7) begin
          if (junk_q) begin
            junk_q  <= 1'b0;
            shreg   <= ram_rdata;
            rd_ptr  <= next_ptr;
            byte_no <= '0;
          end else if (byte_no == last_idx && !cyc_q) begin
            state  <= ST_IDLE;
            irq_q  <= 1'b1;
            cnt_q  <= '0;
            rd_ptr <= '0;
            shreg  <= FILL_OCTET;
          end else begin
            shreg   <= ram_rdata;
            rd_ptr  <= next_ptr;
            byte_no <= (byte_no == last_idx) ? '0 : byte_no + 1'b1;
          end
        end
      end
    end
  end

  // R2: the fill level never exceeds the buffer depth
  p_count_cap_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));

  // R10: writes leave the fill level alone once a transmission is under way
  p_busy_write_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cmd_valid && (state == ST_ARM || (state == ST_RUN && cyc_q)))
      |=> $stable(cnt_q));

  // R6: the read pointer stays within the stored bytes while running
  p_ptr_range_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (CW'(rd_ptr) < cnt_q));

  // R5: the done flag is only raised by a single-shot transmission
  p_irq_single_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> !cyc_q);

  // R7: a transmit reset returns to idle with an empty buffer
  p_txreset_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte[CMD_RESET_BIT]) |=> (state == ST_IDLE && cnt_q == '0));

  // R11: a start with an empty buffer does not leave idle
  p_start_empty_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && state == ST_IDLE && cnt_q == '0) |=> (state == ST_IDLE));
endmodule

// File: rtl/cyctx_line_out.sv
module cyctx_line_out (
  input  logic clk,
  input  logic rst,
  input  logic slot_act,
  input  logic tx_bit,
  input  logic hold_high,
  output logic txd,
  output logic txd_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      txd    <= 1'b1;
      txd_oe <= 1'b0;
    end else if (slot_act) begin
      txd    <= tx_bit;
      txd_oe <= 1'b1;
    end else begin
      txd    <= 1'b1;
      txd_oe <= hold_high;
    end
  end

  // R12: a timeslot bit is always driven in the following cycle
  p_slot_drive_r12: assert property (@(posedge clk) disable iff (rst)
    slot_act |=> txd_oe);
endmodule

// File: rtl/cyc_serial_tx.sv
module cyc_serial_tx
  import cyctx_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int FRAME_BITS = 32,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync,
  input  logic [POS_W-1:0] slot_pos,
  input  logic [POS_W:0]   slot_len,
  input  logic             hold_high,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  output logic             txd,
  output logic             txd_oe,
  output logic [7:0]       irq_flags
);
  localparam int AW = $clog2(DEPTH);

  logic          slot_act, slot_aligned;
  logic          tx_bit, eng_idle, irq_done;
  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [7:0]    ram_wdata, ram_rdata;

  cyctx_slot_timer #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_timer (
    .clk(clk), .rst(rst), .fsync(fsync), .slot_pos(slot_pos), .slot_len(slot_len),
    .slot_act(slot_act), .slot_aligned(slot_aligned)
  );

  cyctx_buf_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  cyctx_engine #(.DEPTH(DEPTH), .AW(AW)) u_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .slot_act(slot_act), .slot_aligned(slot_aligned),
    .tx_bit(tx_bit), .eng_idle(eng_idle), .irq_done(irq_done),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata)
  );

  cyctx_line_out u_line (
    .clk(clk), .rst(rst), .slot_act(slot_act), .tx_bit(tx_bit),
    .hold_high(hold_high), .txd(txd), .txd_oe(txd_oe)
  );

  assign irq_flags = 8'(irq_done) << IRQ_DONE_BIT;

  // R1: with the engine idle over two cycles the line shows a one
  p_idle_ones_r1: assert property (@(posedge clk) disable iff (rst)
    (eng_idle && $past(eng_idle)) |-> txd);
endmodule

// File: tb/cyc_serial_tx_test.sv
module cyc_serial_tx_test;
  localparam int FB = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsync = 1'b1;
  logic [4:0] slot_pos = 5'd4;
  logic [5:0] slot_len = 6'd8;
  logic       hold_high = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       txd, txd_oe;
  logic [7:0] irq_flags;

  int errors = 0;
  int checks = 0;
  int bpos = 0;
  int seen = 0;
  int n = 0;
  bit sb [0:8191];
  bit si [0:8191];
  int so [0:8191];

  cyc_serial_tx uut (
    .clk(clk), .rst(rst), .fsync(fsync), .slot_pos(slot_pos), .slot_len(slot_len),
    .hold_high(hold_high), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .txd(txd), .txd_oe(txd_oe), .irq_flags(irq_flags)
  );

  always #5 clk = ~clk;

  // frame generator: seen = position processed at the last edge
  always @(posedge clk) begin
    seen  <= bpos;
    bpos  <= (bpos + 1) % FB;
    fsync <= (((bpos + 1) % FB) == 0);
  end

  function automatic bit in_slot(int p);
    return (p >= int'(slot_pos)) && (p < int'(slot_pos) + int'(slot_len));
  endfunction

  // capture every timeslot bit driven on txd
  always @(posedge clk) begin
    #3;
    if (!rst && in_slot(seen) && n < 8192) begin
      sb[n] = txd;
      si[n] = irq_flags[6];
      so[n] = seen - int'(slot_pos);
      n = n + 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_byte(logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send_cmd(logic [7:0] c);
    cmd_byte = c; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_bits(int k);
    while (n < k) @(negedge clk);
  endtask

  function automatic int find_zero(int from);
    for (int i = from; i < n; i++) if (sb[i] == 1'b0) return i;
    return -1;
  endfunction

  function automatic int get_byte(int i);
    int v = 0;
    for (int k = 0; k < 8; k++) v = (v << 1) | int'(sb[i + k]);
    return v;
  endfunction

  function automatic int count_zeros(int from, int len);
    int c = 0;
    for (int i = from; i < from + len; i++) if (sb[i] == 1'b0) c++;
    return c;
  endfunction

  task automatic t_reset();
    chk(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(irq_flags == 8'h00, "R1 irq after reset", int'(irq_flags), 0);
    repeat (2 * FB) @(negedge clk);
    chk(n > 0 && count_zeros(0, n) == 0, "R1 idle slot ones", count_zeros(0, n), 0);
  endtask

  task automatic t_oe();
    int bad = 0;
    hold_high = 1'b0;
    repeat (2) @(negedge clk);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (in_slot(seen)) begin if (txd_oe !== 1'b1) bad++; end
      else if (txd_oe !== 1'b0 || txd !== 1'b1) bad++;
    end
    chk(bad == 0, "R12 released outside slot", bad, 0);
    hold_high = 1'b1;
    repeat (2) @(negedge clk);
    bad = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (txd_oe !== 1'b1 || (!in_slot(seen) && txd !== 1'b1)) bad++;
    end
    chk(bad == 0, "R12 held high outside slot", bad, 0);
  endtask

  task automatic t_single();
    logic [7:0] d [3] = '{8'h3C, 8'hA5, 8'h0F};
    int m, z, bad;
    slot_pos = 5'd4; slot_len = 6'd8;
    foreach (d[i]) write_byte(d[i]);
    @(negedge clk);
    m = n;
    send_cmd(8'h08);
    wait_bits(m + 64);
    z = find_zero(m);
    chk(z >= m + 8 && z <= m + 16, "R8 filler octet before data", z - m, 8);
    chk(z >= 0 && (so[z] % 8) == 0, "R9 octet starts on slot boundary", so[z], 0);
    bad = 0;
    for (int i = 0; i < 3; i++) if (get_byte(z + 8 * i) != int'(d[i])) bad++;
    chk(bad == 0, "R3 bytes MSB first as stored", get_byte(z), int'(d[0]));
    chk(count_zeros(z + 24, 16) == 0, "R4 ones after single shot", count_zeros(z + 24, 16), 0);
    chk(si[z + 23] == 1'b1 && si[z + 22] == 1'b0, "R5 flag rises with last bit",
        int'({si[z + 22], si[z + 23]}), 1);
    chk(irq_flags == 8'h40, "R5 flag field", int'(irq_flags), 8'h40);
  endtask

  task automatic t_cyclic();
    logic [7:0] d [5] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A};
    int m, z, bad;
    slot_pos = 5'd8; slot_len = 6'd16;
    foreach (d[i]) write_byte(d[i]);
    @(negedge clk);
    while (seen != 8 + 10) @(negedge clk);
    m = n;
    send_cmd(8'h2A);
    wait_bits(m + 48);
    write_byte(8'h00);
    @(negedge clk);
    send_cmd(8'h08);
    wait_bits(m + 230);
    z = find_zero(m);
    chk(z >= 8 && so[z] == 8 && so[z - 8] == 0, "R9 first data in second sub-slot", so[z], 8);
    chk(z >= 8 && get_byte(z - 8) == 8'hFF, "R8 filler octet value", get_byte(z - 8), 8'hFF);
    bad = 0;
    for (int i = 0; i < 5; i++) if (get_byte(z + 8 * i) != int'(d[i])) bad++;
    chk(bad == 0, "R6 first pass of buffer", bad, 0);
    bad = 0;
    for (int i = 5; i < 25; i++) if (get_byte(z + 8 * i) != int'(d[i % 5])) bad++;
    chk(bad == 0, "R6 R10 R11 repeats with period of five bytes", bad, 0);
    chk(irq_flags == 8'h00, "R5 flag cleared and not set by repeat", int'(irq_flags), 0);
  endtask

  task automatic t_txreset();
    int m;
    @(negedge clk);
    send_cmd(8'h09);
    repeat (2) @(negedge clk);
    m = n;
    wait_bits(m + 48);
    chk(count_zeros(m, 48) == 0, "R7 ones after transmit reset", count_zeros(m, 48), 0);
    @(negedge clk);
    m = n;
    send_cmd(8'h08);
    wait_bits(m + 48);
    chk(count_zeros(m, 48) == 0, "R11 start with empty buffer ignored", count_zeros(m, 48), 0);
    chk(irq_flags == 8'h00, "R7 R11 no flag", int'(irq_flags), 0);
  endtask

  task automatic t_full();
    int m, z, bad;
    slot_pos = 5'd0; slot_len = 6'd16;
    for (int i = 0; i < 64; i++) write_byte(8'(i + 1));
    write_byte(8'h80);
    @(negedge clk);
    m = n;
    send_cmd(8'h08);
    wait_bits(m + 600);
    z = find_zero(m);
    bad = 0;
    for (int i = 0; i < 64; i++) if (get_byte(z + 8 * i) != i + 1) bad++;
    chk(z >= m + 8 && bad == 0, "R2 all 64 bytes sent", bad, 0);
    chk(count_zeros(z + 512, 48) == 0, "R2 write beyond depth ignored",
        count_zeros(z + 512, 48), 0);
    chk(irq_flags == 8'h40, "R5 flag after full buffer", int'(irq_flags), 8'h40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_oe();
    t_single();
    t_cyclic();
    t_txreset();
    t_full();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule